// File: doc/BRIEF.md
# Delta-Sigma Converter Cycle Sequencer

This block is the digital sequencer on the device side of a single-channel 16-bit delta-sigma converter. It runs a fixed loop of three phases: a timed conversion, a low-power hold, and a serial exchange. The exchange happens on a slave port with chip select, serial clock, data in and data out. Data out comes with a separate drive-enable for the pad. A cycle counter stands in for the modulator. The block issues a one-cycle start pulse and, when the programmed duration has elapsed, latches the 16-bit word presented on `resultIn`. It also drives power controls for the converter core and for the reference.

A host lowers chip select to read the latest result, most significant bit first. On the first four rising serial-clock edges the same transaction carries a small configuration word. That word selects the conversion rate and whether the reference sleeps between conversions. The next conversion starts by itself when the 16th bit has been clocked out, or when chip select is raised early. Because there is no pipeline latency, every read returns the conversion that finished just before it.

The serial pins are asynchronous to `clk`. Each passes through a two-stage synchronizer, and edges are detected in the system clock domain.

Top module: `adc_cycle_ctrl`

## Requirements
- R1: After reset the block issues one `convStart` pulse and begins a conversion at the slow rate with sleep disabled. `sdoOe` is 0 while `csN` is high, and `refPowerOn` is 1.
- R2: `adcPowerOn` stays high for exactly `SLOW_CYCLES` clock cycles when the rate bit is 0, and for exactly `FAST_CYCLES` cycles when it is 1. Once started, a conversion always runs to its end.
- R3: When a conversion ends with `csN` high, `adcPowerOn` goes low and the block waits with no further `convStart` for as long as `csN` stays high.
- R4: When `csN` goes low in the wait phase, `sdo` presents bit 15 of the word latched at the end of the last conversion, before any serial clock edge.
- R5: Each falling edge of `sclk` advances `sdo` to the next lower bit, so the word is delivered from bit 15 down to bit 0.
- R6: The 16th falling edge of `sclk` ends the exchange and produces exactly one `convStart` pulse.
- R7: A low-to-high transition of `csN` during the exchange ends it at once and produces exactly one `convStart` pulse.
- R8: The `sdi` values sampled on the first four rising `sclk` edges form a word, first bit in bit 3. Bit 3 and bit 2 form an enable key. Only when the key is 1 then 0 does the block store bit 1 as the rate bit (1 = fast) and bit 0 as the sleep bit. Any other key, and every `sdi` bit after the fourth, leaves both unchanged. Both take effect on the next conversion.
- R9: `refPowerOn` is 0 only in the wait phase when the sleep bit is 1. It returns to 1 as soon as `csN` low is seen. With the sleep bit 0 the reference stays powered throughout.
- R10: If `csN` goes low during a conversion, the conversion still runs for its full length. The block then enters the exchange directly with no extra `convStart`, and `sdo` shows bit 15 of the new result.
- R11: `sdoOe` is 1 exactly while `csN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial configuration data, sampled on rising `sclk` |
| sdo | output | 1 | Serial result data |
| sdoOe | output | 1 | Drive enable for the `sdo` pad |
| resultIn | input | 16 | Result word from the modulator, latched at conversion end |
| convStart | output | 1 | One-cycle pulse at the start of each conversion |
| adcPowerOn | output | 1 | Converter core powered, high for the whole conversion |
| refPowerOn | output | 1 | Reference powered |

## Verification
Full 16-bit reads with known words show the bit order and the data path through the result latch. Reads aborted after two to five bits show the early-exit path apart from completion, and they show that a configuration word shorter than four bits is never committed. Configuration words with a correct key, with a wrong key, and with random trailing bits show key decoding apart from the rate and sleep fields. The measured length of each following conversion and the reference state in the wait phase show whether a field was stored. Lowering chip select mid-conversion, in contrast to lowering it in the wait phase, shows that a conversion cannot be cut short and that the hold phase is skipped.

// File: rtl/adc_cycle_pkg.sv
package adc_cycle_pkg;

  localparam int WORD_W = 16;
  localparam int CFG_W  = 4;

  // positions inside the captured configuration word (first bit received lands in the top)
  localparam int KEY_SET_POS = 3;
  localparam int KEY_CLR_POS = 2;
  localparam int RATE_POS    = 1;
  localparam int SLEEP_POS   = 0;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_CONV  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_XFER  = 2'd3
  } cycState_t;

  typedef struct packed {
    logic startConv;
    logic capture;
    logic loadOut;
    logic shiftOut;
    logic sampleCfg;
  } dpStrobe_t;

  typedef struct packed {
    logic timerDone;
    logic lastFall;
  } dpStatus_t;

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int         N      = 3,
  parameter int         STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] pinIn,
  output logic [N-1:0] pinOut
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= {STAGES{IDLE[g]}};
      else       pipe <= {pipe[STAGES-2:0], pinIn[g]};
    end
    assign pinOut[g] = pipe[STAGES-1];
  end

endmodule

// File: rtl/adc_cycle_dp.sv
module adc_cycle_dp
  import adc_cycle_pkg::*;
#(
  parameter int SLOW_CYCLES = 200000,
  parameter int FAST_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] resultIn,
  input  logic              sdiBit,
  output dpStatus_t         status,
  output logic              sdoBit,
  output logic              sleepSel
);

  localparam int CNT_W  = $clog2(SLOW_CYCLES);
  localparam int FALL_W = $clog2(WORD_W);
  localparam int RISE_W = $clog2(CFG_W + 1);

  logic [CNT_W-1:0]  timer;
  logic              rateFast;
  logic [WORD_W-1:0] held;
  logic [WORD_W-1:0] shifter;
  logic [FALL_W-1:0] fallCnt;
  logic [RISE_W-1:0] riseCnt;
  logic [CFG_W-2:0]  cfgSh;
  logic [CFG_W-1:0]  cfgWord;

  // conversion timer: loaded at start, counts down to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.startConv) begin
      timer <= rateFast ? CNT_W'(FAST_CYCLES - 1) : CNT_W'(SLOW_CYCLES - 1);
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  // result latch and output shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held    <= '0;
      shifter <= '0;
      fallCnt <= '0;
    end else begin
      if (strobe.capture) held <= resultIn;
      if (strobe.loadOut) begin
        shifter <= strobe.capture ? resultIn : held;
        fallCnt <= '0;
      end else if (strobe.shiftOut) begin
        shifter <= {shifter[WORD_W-2:0], 1'b0};
        fallCnt <= fallCnt + 1'b1;
      end
    end
  end

  // configuration capture on the first CFG_W rising edges
  assign cfgWord = {cfgSh, sdiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCnt  <= '0;
      cfgSh    <= '0;
      rateFast <= 1'b0;
      sleepSel <= 1'b0;
    end else if (strobe.loadOut) begin
      riseCnt <= '0;
    end else if (strobe.sampleCfg && riseCnt < RISE_W'(CFG_W)) begin
      riseCnt <= riseCnt + 1'b1;
      cfgSh   <= cfgWord[CFG_W-2:0];
      if (riseCnt == RISE_W'(CFG_W - 1) && cfgWord[KEY_SET_POS] && !cfgWord[KEY_CLR_POS]) begin
        rateFast <= cfgWord[RATE_POS];
        sleepSel <= cfgWord[SLEEP_POS];
      end
    end
  end

  assign status.timerDone = (timer == '0);
  assign status.lastFall  = (fallCnt == FALL_W'(WORD_W - 1));
  assign sdoBit           = shifter[WORD_W-1];

endmodule

// File: rtl/adc_cycle_fsm.sv
module adc_cycle_fsm
  import adc_cycle_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csLvl,
  input  logic      sclkLvl,
  input  dpStatus_t status,
  input  logic      sleepSel,
  output dpStrobe_t strobe,
  output logic      convStart,
  output logic      adcPowerOn,
  output logic      refPowerOn
);

  cycState_t state, nextState;
  logic csPrev, sclkPrev;
  logic csRise, sclkRise, sclkFall, csLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_START;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      state    <= nextState;
      csPrev   <= csLvl;
      sclkPrev <= sclkLvl;
    end
  end

  assign csRise   = csLvl & ~csPrev;
  assign csLow    = ~csLvl;
  assign sclkRise = sclkLvl & ~sclkPrev;
  assign sclkFall = ~sclkLvl & sclkPrev;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_START: begin
        strobe.startConv = 1'b1;
        nextState        = ST_CONV;
      end
      ST_CONV: begin
        if (status.timerDone) begin
          strobe.capture = 1'b1;
          if (csLow) begin
            strobe.loadOut = 1'b1;
            nextState      = ST_XFER;
          end else begin
            nextState = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (csLow) begin
          strobe.loadOut = 1'b1;
          nextState      = ST_XFER;
        end
      end
      ST_XFER: begin
        if (csRise) begin
          nextState = ST_START;
        end else begin
          if (sclkRise) strobe.sampleCfg = 1'b1;
          if (sclkFall) begin
            strobe.shiftOut = 1'b1;
            if (status.lastFall) nextState = ST_START;
          end
        end
      end
      default: nextState = ST_START;
    endcase
  end

  assign convStart  = (state == ST_START);
  assign adcPowerOn = (state == ST_CONV);
  assign refPowerOn = !((state == ST_WAIT) && sleepSel);

endmodule

// File: rtl/adc_cycle_ctrl.sv
module adc_cycle_ctrl
  import adc_cycle_pkg::*;
#(
  parameter int SLOW_CYCLES = 200000,
  parameter int FAST_CYCLES = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  input  logic [WORD_W-1:0] resultIn,
  output logic              convStart,
  output logic              adcPowerOn,
  output logic              refPowerOn
);

  logic [2:0] pinSync;
  dpStrobe_t  strobe;
  dpStatus_t  status;
  logic       sleepSel;

  adc_pin_sync #(
    .N(3),
    .STAGES(SYNC_STAGES),
    .IDLE(3'b001)
  ) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .pinIn ({sdi, sclk, csN}),
    .pinOut(pinSync)
  );

  adc_cycle_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .csLvl     (pinSync[0]),
    .sclkLvl   (pinSync[1]),
    .status    (status),
    .sleepSel  (sleepSel),
    .strobe    (strobe),
    .convStart (convStart),
    .adcPowerOn(adcPowerOn),
    .refPowerOn(refPowerOn)
  );

  adc_cycle_dp #(
    .SLOW_CYCLES(SLOW_CYCLES),
    .FAST_CYCLES(FAST_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .resultIn(resultIn),
    .sdiBit  (pinSync[2]),
    .status  (status),
    .sdoBit  (sdo),
    .sleepSel(sleepSel)
  );

  assign sdoOe = ~csN;

endmodule

// File: rtl/adc_cycle_ctrl_sva.sv
module adc_cycle_ctrl_sva #(
  parameter int SLOW_CYCLES = 200000,
  parameter int FAST_CYCLES = 50000
) (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic adcPowerOn,
  input logic refPowerOn
);

  int convLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          convLen <= 0;
    else if (adcPowerOn) convLen <= convLen + 1;
    else                 convLen <= 0;
  end

  // R1: a start pulse lasts one cycle and is followed by conversion
  a_r1_start_then_convert: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> (adcPowerOn && !convStart));

  // R2: a conversion never outlasts the slow duration
  a_r2_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    adcPowerOn |-> (convLen < SLOW_CYCLES));

  // R2: a finished conversion lasted one of the two programmed durations
  a_r2_len_exact: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcPowerOn) |-> (convLen == SLOW_CYCLES || convLen == FAST_CYCLES));

  // R9: reference is powered while converting
  a_r9_ref_while_converting: assert property (@(posedge clk) disable iff (!rstN)
    adcPowerOn |-> refPowerOn);

  // R6: every conversion is preceded by a start pulse
  a_r6_convert_after_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcPowerOn) |-> $past(convStart));

endmodule

bind adc_cycle_ctrl adc_cycle_ctrl_sva #(
  .SLOW_CYCLES(SLOW_CYCLES),
  .FAST_CYCLES(FAST_CYCLES)
) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .convStart (convStart),
  .adcPowerOn(adcPowerOn),
  .refPowerOn(refPowerOn)
);

// File: tb/adc_cycle_ctrl_bench.sv
module adc_cycle_ctrl_bench;

  localparam int SLOW = 300;
  localparam int FAST = 80;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdoOe;
  logic [15:0] resultIn = 16'hA5C3;
  logic        convStart, adcPowerOn, refPowerOn;

  int compared = 0;
  int mismatched = 0;
  int starts = 0;
  int ends = 0;
  int runLen = 0;
  int lastLen = 0;
  bit finished = 0;

  logic        modelFast = 1'b0;
  logic        modelSleep = 1'b0;
  logic [15:0] expWord;
  logic        oeWhenLow;
  logic        refWhenLow;

  always #10 clk = ~clk;

  adc_cycle_ctrl #(.SLOW_CYCLES(SLOW), .FAST_CYCLES(FAST)) u_adc_cycle_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .resultIn(resultIn),
    .convStart(convStart), .adcPowerOn(adcPowerOn), .refPowerOn(refPowerOn)
  );

  // output monitor: counts start pulses and measures conversion lengths
  always @(posedge clk) begin
    if (rstN) begin
      if (convStart) starts = starts + 1;
      if (adcPowerOn) runLen = runLen + 1;
      else if (runLen > 0) begin
        lastLen = runLen;
        runLen = 0;
        ends = ends + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expLen(input logic fast);
    return fast ? FAST : SLOW;
  endfunction

  // model of the configuration commit rule (R8)
  function automatic logic [1:0] applyCfg(input logic [1:0] cur, input logic [3:0] cfg, input int rises);
    if (rises >= 4 && cfg[3] && !cfg[2]) return cfg[1:0];
    return cur;
  endfunction

  task automatic waitConvEnd();
    int target = ends + 1;
    while (ends < target) @(negedge clk);
  endtask

  task automatic xfer(input logic [3:0] cfg, input int nFalls, output logic [15:0] got);
    got = '0;
    csN = 1'b0;
    repeat (6) @(negedge clk);
    oeWhenLow = sdoOe;
    refWhenLow = refPowerOn;
    got[15] = sdo;
    for (int i = 0; i < nFalls; i++) begin
      sdi = (i < 4) ? cfg[3-i] : 1'($urandom);
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (5) @(negedge clk);
      sclk = 1'b0;
      repeat (5) @(negedge clk);
      if (i < 15) got[14-i] = sdo;
    end
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic readAndCheck(input string tag, input logic [3:0] cfg, input int nFalls);
    logic [15:0] got;
    logic [15:0] mask;
    logic [1:0]  nxt;
    int s0 = starts;
    xfer(cfg, nFalls, got);
    mask = (nFalls >= 15) ? 16'hFFFF : (16'hFFFF << (15 - nFalls));
    chk({tag, " R4 R5 data"}, 32'(got & mask), 32'(expWord & mask));
    chk({tag, " R11 oe low"}, 32'(oeWhenLow), 32'd1);
    chk({tag, (nFalls >= 16) ? " R6 one start" : " R7 one start"}, 32'(starts), 32'(s0 + 1));
    nxt = applyCfg({modelFast, modelSleep}, cfg, (nFalls >= 16) ? 16 : nFalls);
    modelFast = nxt[1];
    modelSleep = nxt[0];
  endtask

  task automatic newResultAndWait(input string tag, input logic [15:0] w);
    resultIn = w;
    expWord = w;
    waitConvEnd();
    @(negedge clk);
    chk({tag, " R2 R8 length"}, 32'(lastLen), 32'(expLen(modelFast)));
    chk({tag, " R9 ref in wait"}, 32'(refPowerOn), 32'(!modelSleep));
    chk({tag, " R3 core off"}, 32'(adcPowerOn), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int s0;
    void'($urandom(32'h1BADF00D));
    expWord = resultIn;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 start after reset", 32'(starts), 32'd1);
    chk("R1 R11 oe idle", 32'(sdoOe), 32'd0);
    chk("R1 ref on", 32'(refPowerOn), 32'd1);
    chk("R2 converting", 32'(adcPowerOn), 32'd1);

    waitConvEnd();
    @(negedge clk);
    chk("R1 R2 default slow", 32'(lastLen), 32'(SLOW));
    chk("R9 nap keeps ref", 32'(refPowerOn), 32'd1);
    s0 = starts;
    repeat (60) @(negedge clk);
    chk("R3 no start while waiting", 32'(starts), 32'(s0));
    chk("R3 core stays off", 32'(adcPowerOn), 32'd0);

    // plain read, no key
    readAndCheck("plain", 4'b0000, 16);
    newResultAndWait("plain", 16'h3C5A);

    // key ok, fast rate
    readAndCheck("fast", 4'b1010, 16);
    newResultAndWait("fast", 16'h8001);

    // wrong key (second key bit set) leaves fast rate
    readAndCheck("badkey", 4'b1100, 16);
    newResultAndWait("badkey", 16'h7FFE);

    // abort after three bits: no commit
    readAndCheck("abort3", 4'b1000, 3);
    newResultAndWait("abort3", 16'h1234);

    // slow rate with reference sleep
    readAndCheck("sleep", 4'b1001, 16);
    newResultAndWait("sleep", 16'hFFFF);
    readAndCheck("wake", 4'b0000, 16);
    chk("R9 ref back on at cs low", 32'(refWhenLow), 32'd1);
    newResultAndWait("wake", 16'h0000);

    // back to nap, slow
    readAndCheck("nap", 4'b1000, 16);
    newResultAndWait("nap", 16'hC0DE);
    readAndCheck("nap2", 4'b0110, 16);

    // chip select low while converting
    resultIn = 16'h9ABC;
    expWord = 16'h9ABC;
    repeat (10) @(negedge clk);
    csN = 1'b0;
    waitConvEnd();
    s0 = starts;
    repeat (6) @(negedge clk);
    chk("R10 full length", 32'(lastLen), 32'(expLen(modelFast)));
    chk("R10 new msb", 32'(sdo), 32'(expWord[15]));
    chk("R10 no extra start", 32'(starts), 32'(s0));
    chk("R10 ref on", 32'(refPowerOn), 32'd1);
    readAndCheck("R10 read", 4'b0000, 16);
    newResultAndWait("after R10", 16'h5555);

    // random mix
    for (int k = 0; k < 10; k++) begin
      logic [3:0] cfg;
      int nf;
      cfg = 4'($urandom);
      if (k % 3 == 0) cfg = {2'b10, 2'($urandom)};
      case (k % 5)
        1: nf = 2;
        3: nf = 5;
        default: nf = 16;
      endcase
      readAndCheck("random", cfg, nf);
      newResultAndWait("random", 16'($urandom));
    end

    chk("R11 oe idle at end", 32'(sdoOe), 32'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule